// File: doc/BRIEF.md
# System Control Register Block

This block is a small control-and-scratch register file that hangs off a 32-bit APB-style slave port. It decodes a 4 KiB byte window. Only the lower part of that window has storage behind it: 512 words of 32 bits, addressed by word index, which is the byte offset shifted right by two. A handful of words leave reset holding fixed identification-style constants. Every other word starts at zero.

Three word locations are status views. On a read they return the stored value with two high bits forced to one, and the stored word itself stays unchanged. One location in the unbacked part of the window is a command port. Writing a command code there produces a one-cycle request pulse towards the chip's reset controller, either a reset request or a shutdown request. Any access to the unbacked part of the window signals a slave error, returns zero on a read and stores nothing.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word index 0x40 (byte 0x100) holds 0x05F20121, index 0x41 holds 0x00000002, index 0x42 holds 0x05F30121, index 0x43 holds 0x05F40121, and every other word holds zero.
- R2: A write in the access phase (psel=1, penable=1, pwrite=1) with word index paddr[11:2] below 512 replaces that whole word with pwdata. paddr[1:0] plays no part in selecting the word.
- R3: A read at word index 0x40, 0x42 or 0x43 returns the stored word OR 0x30000000. A read at any other in-range index returns the stored word unmodified.
- R4: An access with word index 512 or above (byte offset 0x800 and up) asserts pslverr in its access phase, returns prdata of zero on a read, and changes no stored word.
- R5: pready is always 1, and pslverr is 0 for every in-range access and whenever no access phase is present.
- R6: A write access at word index 0x3C0 (byte 0xF00) with pwdata equal to 1 or 2 raises rst_req for exactly one cycle, in the cycle that follows the clock edge closing the access phase.
- R7: A write at word index 0x3C0 with pwdata equal to 3 raises shut_req for one cycle with the same timing as R6. Any other data value raises neither request, and the two requests are never high together.
- R8: A read at word index 0x3C0 raises no request. A write of a command code to any other index raises no request.
- R9: While rst is high and in the cycle after it, rst_req and shut_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Ready, tied high |
| pslverr | output | 1 | Error for accesses beyond the storage |
| rst_req | output | 1 | One-cycle system reset request |
| shut_req | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the block with its default parameters: a 512-word store, a 12-bit byte address and 32-bit data. With those values the random addresses reach both the backed half and the unbacked half of the window. The same parameters bring the boundary pair 0x7FC/0x800, the command port at 0xF00 and the three forced-status words into reach in a single build. An out-of-range write at 0x804 would alias word 1 if the index were truncated, and a later read of word 1 exposes that.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int WIDX_W  = ADDR_W - 2;

    localparam logic [WIDX_W-1:0] CMD_WIDX    = 10'h3C0;
    localparam logic [DATA_W-1:0] STATUS_MASK = 32'h3000_0000;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_RESET    = 2'd1,
        CMD_SHUTDOWN = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic              access;
        logic              write;
        logic              in_range;
        logic              cmd_hit;
        logic              forced;
        logic [WIDX_W-1:0] widx;
    } bus_acc_t;

    function automatic cmd_kind_e classify_cmd(input logic [DATA_W-1:0] d);
        if (d == 32'd1 || d == 32'd2) return CMD_RESET;
        if (d == 32'd3)               return CMD_SHUTDOWN;
        return CMD_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] power_on_word(input int idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return '0;
        endcase
    endfunction

    function automatic logic status_view(input logic [WIDX_W-1:0] w);
        return (w == 10'h40) || (w == 10'h42) || (w == 10'h43);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output bus_acc_t          acc
);
    logic [WIDX_W-1:0] widx;

    always_comb begin
        widx         = paddr[ADDR_W-1:2];
        acc.access   = psel & penable;
        acc.write    = pwrite;
        acc.widx     = widx;
        acc.in_range = (int'(widx) < DEPTH);
        acc.cmd_hit  = (widx == CMD_WIDX);
        acc.forced   = status_view(widx);
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= power_on_word(i);
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/sysctl_req.sv
module sysctl_req
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] wdata,
    output logic              rst_req,
    output logic              shut_req
);
    cmd_kind_e kind;

    assign kind = fire ? classify_cmd(wdata) : CMD_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            shut_req <= 1'b0;
        end else begin
            rst_req  <= (kind == CMD_RESET);
            shut_req <= (kind == CMD_SHUTDOWN);
        end
    end

    p_never_both_r7: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && shut_req));
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    p_shut_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        shut_req |=> !shut_req);
    p_rst_cause_r6: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(fire));
    p_shut_cause_r7: assert property (@(posedge clk) disable iff (rst)
        shut_req |-> $past(fire));
    p_quiet_reset_r9: assert property (@(posedge clk)
        rst |=> (!rst_req && !shut_req));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [11:0]       paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              rst_req,
    output logic              shut_req
);
    bus_acc_t          acc;
    logic [DATA_W-1:0] store_q;

    sysctl_decode #(.DEPTH(DEPTH)) u_decode (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .acc     (acc)
    );

    sysctl_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.access & acc.write & acc.in_range),
        .idx   (acc.widx[IDX_W-1:0]),
        .wdata (pwdata),
        .rdata (store_q)
    );

    sysctl_req u_req (
        .clk      (clk),
        .rst      (rst),
        .fire     (acc.access & acc.write & acc.cmd_hit),
        .wdata    (pwdata),
        .rst_req  (rst_req),
        .shut_req (shut_req)
    );

    always_comb begin
        if (!acc.in_range)   prdata = '0;
        else if (acc.forced) prdata = store_q | STATUS_MASK;
        else                 prdata = store_q;
    end

    assign pready  = 1'b1;
    assign pslverr = acc.access & ~acc.in_range;

    p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (prdata == '0));
    p_err_phase_r5: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (psel && penable));
    p_ready_r5: assert property (@(posedge clk) disable iff (rst)
        pready);
endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, rst_req, shut_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] model [512];

    always #2 clk = ~clk;

    sysctl_regs dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rst_req(rst_req), .shut_req(shut_req)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [9:0]  w = a[11:2];
        logic [31:0] v;
        if (w >= 10'd512) return 32'h0;
        v = model[w];
        if (w == 10'h40 || w == 10'h42 || w == 10'h43) v = v | 32'h3000_0000;
        return v;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] d);
        logic cmd = we && (a[11:2] == 10'h3C0);
        logic er  = cmd && (d == 32'd1 || d == 32'd2);
        logic es  = cmd && (d == 32'd3);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = we; paddr = a; pwdata = d;
        #1;
        check("R5 idle pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        penable = 1'b1;
        #1;
        check("R5 pready", {31'b0, pready}, 32'd1);
        check(a[11:2] >= 10'd512 ? "R4 pslverr" : "R5 pslverr",
              {31'b0, pslverr}, {31'b0, (a[11:2] >= 10'd512)});
        if (!we) check(a[11:2] >= 10'd512 ? "R4 read zero" : "R3 read data",
                       prdata, exp_read(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        #1;
        check("R6 rst_req pulse", {31'b0, rst_req}, {31'b0, er});
        check("R7 shut_req pulse", {31'b0, shut_req}, {31'b0, es});
        if (we && a[11:2] < 10'd512) model[a[11:2]] = d;
        @(negedge clk);
        #1;
        check("R8 requests quiet", {30'b0, rst_req, shut_req}, 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 512; i++) model[i] = 32'h0;
        model[9'h40] = 32'h05F2_0121;
        model[9'h41] = 32'h0000_0002;
        model[9'h42] = 32'h05F3_0121;
        model[9'h43] = 32'h05F4_0121;

        repeat (3) @(negedge clk);
        #1;
        check("R9 quiet in reset", {30'b0, rst_req, shut_req}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 quiet after reset", {30'b0, rst_req, shut_req}, 32'd0);

        // R1: reset contents, including the forced status views (R3)
        bus_op(1'b0, 12'h100, 32'h0);
        bus_op(1'b0, 12'h104, 32'h0);
        bus_op(1'b0, 12'h108, 32'h0);
        bus_op(1'b0, 12'h10C, 32'h0);
        bus_op(1'b0, 12'h000, 32'h0);
        bus_op(1'b0, 12'h7FC, 32'h0);
        checks++;
        if (model[9'h41] !== 32'h2) begin fails++; $display("FAIL R1 model"); end

        // R2: full-word write, low address bits ignored
        bus_op(1'b1, 12'h013, 32'hDEAD_BEEF);
        bus_op(1'b0, 12'h010, 32'h0);
        bus_op(1'b1, 12'h7FC, 32'h1234_5678);
        bus_op(1'b0, 12'h7FE, 32'h0);
        // R3: forced bits over a cleared word, unforced neighbour
        bus_op(1'b1, 12'h100, 32'h0);
        bus_op(1'b0, 12'h100, 32'h0);
        bus_op(1'b1, 12'h104, 32'hFFFF_FFFF);
        bus_op(1'b0, 12'h104, 32'h0);
        // R4: out of range write must not alias word 1
        bus_op(1'b1, 12'h804, 32'hA5A5_A5A5);
        bus_op(1'b0, 12'h004, 32'h0);
        bus_op(1'b0, 12'h800, 32'h0);
        bus_op(1'b0, 12'hFFC, 32'h0);
        // R6/R7/R8: command port
        bus_op(1'b1, 12'hF00, 32'd1);
        bus_op(1'b1, 12'hF00, 32'd2);
        bus_op(1'b1, 12'hF02, 32'd3);
        bus_op(1'b1, 12'hF00, 32'd0);
        bus_op(1'b1, 12'hF00, 32'h101);
        bus_op(1'b0, 12'hF00, 32'd1);
        bus_op(1'b1, 12'hF04, 32'd1);
        bus_op(1'b1, 12'h300, 32'd3);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            logic        we;
            int sel = $urandom_range(0, 9);
            if (sel < 4)       a = {2'b00, 6'h04, 4'h0} + 12'($urandom_range(0, 63));
            else if (sel < 6)  a = 12'hF00 + 12'($urandom_range(0, 3));
            else               a = 12'($urandom);
            sel = $urandom_range(0, 5);
            d = (sel < 4) ? 32'(sel) : $urandom;
            we = $urandom_range(0, 1) == 1;
            bus_op(we, a, d);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule